// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM that is 16 bits wide, has 17 address bits and has a separate active-low enable for each byte. The requester offers one access at a time through a ready/valid handshake. An access is a read or a write with an address, a data word and a two-bit byte mask. The controller then runs the memory's chip enable, write enable, output enable and the two byte enables through a fixed pattern of clock cycles. At the end it returns a single-cycle done pulse, together with the read data when the access was a read.

Every memory timing minimum is given in nanoseconds as a parameter. The clock period is also a parameter. Each window is derived by ceiling division, so changing the clock only needs a new `CLK_NS`. A write is a window in which chip enable, the enabled byte strobes and write enable are all low. Write enable rising is the only edge that ends it. The controller turns on its data drivers only after the memory has had time to release the bus. The read data register samples the bus in the last cycle of the read window and returns zero in the byte lanes the mask leaves out.

Top module: `asram_ctl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte enables are high. The data drive enable is low, reqReady is high and doneValid is low.
- R2: For a read with a nonzero mask, chip enable and output enable are low for exactly RD_N consecutive cycles (12 at default parameters). Write enable stays high and the drive enable stays low. The accepted address is held unchanged on memAddr for the whole window.
- R3: Mask bit 0 controls memLbN and data bits 7:0, and mask bit 1 controls memUbN and bits 15:8, for both directions. The read result holds the bus value from the final cycle of the read window in each enabled lane and zero in each disabled lane.
- R4: For a write with a nonzero mask, chip enable and the enabled byte enables stay low for WR_N cycles (13 at defaults). Write enable is low from the first of these cycles and rises in the last one, so the address and data are released one cycle after the write ends. Write enable is never low unless chip enable and at least one byte enable are also low.
- R5: During a write, output enable stays high. The drive enable comes on only after write enable has been low for HZ_N cycles (5 at defaults). It then stays on to the end of the write, which gives at least DS_N (7) cycles of data before write enable rises.
- R6: A write changes only the byte lanes its mask enables. Other lanes of the stored word keep their earlier contents.
- R7: doneValid is high for exactly one cycle. For a read it comes RD_N cycles after acceptance, and for a write WR_N cycles after. reqReady is high only in the idle state, which follows the done cycle. A request offered while busy is not accepted and does not change memAddr.
- R8: A request with mask 00 produces no memory strobe at all. Done arrives one cycle after acceptance, and the read result is zero.
- R9: Each window is its nanosecond minimum rounded up in cycles with CLK_NS. RD_N is the largest of the cycle time, address access and output-enable access. The write-enable-low span is the larger of the pulse width and HZ_N+DS_N. WR_N is the larger of the cycle time and that span plus one.
- R10: Output enable and write enable are never low together, and the drive enable is never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester offers an access |
| reqReady | output | 1 | Controller is idle and takes the offered access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, valid with doneValid after a read |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |
| memAddr | output | 17 | Memory address |
| memDout | output | 16 | Data toward the memory |
| memDriveEn | output | 1 | Enables the data drivers onto the bus |
| memDin | input | 16 | Data read back from the bus |

## Verification
The bench runs a memory model that presents valid read data only in the final cycle of the window and puts a junk pattern on disabled lanes. A controller that samples one cycle early, or that fails to zero a masked lane, therefore returns a wrong word. Partial writes followed by full readbacks catch swapped or ignored byte lanes, because one lane would be overwritten or left stale. The bench counts strobe cycles and finds the first driving cycle on every write. It also holds a second request during a busy access, which exposes early drive-enable turn-on, a write-enable rise at the wrong cycle, and a controller that accepts work while busy or changes the address mid-cycle. Zero-mask requests catch a design that still pulses chip enable or stalls without completing.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int LANES = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_SKIP,
    PH_DONE
  } phase_e;

  // registered pin-level strobes, all driven straight from flops
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic ubN;
    logic lbN;
    logic driveEn;
    logic ready;
    logic done;
  } pins_t;

  // one-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic capture;
  } dpStrb_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int T_CYCLE_NS = 45,
  parameter int T_ACC_NS   = 45,
  parameter int T_OE_NS    = 22,
  parameter int T_WP_NS    = 35,
  parameter int T_DS_NS    = 25,
  parameter int T_HZ_NS    = 18
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic [1:0] reqMask,
  output pins_t    pins,
  output dpStrb_t  dp
);

  // R9: every window is a ceiling-rounded cycle count
  localparam int CYC_N  = ceilDiv(T_CYCLE_NS, CLK_NS);
  localparam int ACC_N  = ceilDiv(T_ACC_NS, CLK_NS);
  localparam int OE_N   = ceilDiv(T_OE_NS, CLK_NS);
  localparam int WP_N   = ceilDiv(T_WP_NS, CLK_NS);
  localparam int DS_N   = ceilDiv(T_DS_NS, CLK_NS);
  localparam int HZ_N   = ceilDiv(T_HZ_NS, CLK_NS);
  localparam int RD_N   = maxOf(CYC_N, maxOf(ACC_N, OE_N));
  localparam int WLOW_N = maxOf(WP_N, HZ_N + DS_N);
  localparam int WR_N   = maxOf(CYC_N, WLOW_N + 1);
  localparam int MAX_N  = maxOf(RD_N, WR_N);
  localparam int CNT_W  = $clog2(MAX_N + 1);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_N - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_N - 1);
  localparam logic [CNT_W-1:0] HZ_CNT  = CNT_W'(HZ_N);

  phase_e           ph, nxtPh;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic [1:0]       maskQ, nxtMask;
  pins_t            pinQ;
  logic             accept;

  function automatic pins_t pinsFor(input phase_e p, input logic [CNT_W-1:0] c,
                                    input logic [1:0] m);
    pins_t s;
    s = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, ubN: 1'b1, lbN: 1'b1,
          driveEn: 1'b0, ready: 1'b0, done: 1'b0};
    case (p)
      PH_IDLE: s.ready = 1'b1;
      PH_READ: begin
        s.ceN = 1'b0;
        s.oeN = 1'b0;
        s.ubN = ~m[1];
        s.lbN = ~m[0];
      end
      PH_WRITE: begin
        s.ceN     = 1'b0;
        s.ubN     = ~m[1];
        s.lbN     = ~m[0];
        s.weN     = (c == WR_LAST);
        s.driveEn = (c >= HZ_CNT);
      end
      PH_DONE: s.done = 1'b1;
      default: ;
    endcase
    return s;
  endfunction

  assign accept = pinQ.ready && reqValid;

  always_comb begin
    nxtPh   = ph;
    nxtCnt  = cnt;
    nxtMask = maskQ;
    case (ph)
      PH_IDLE: begin
        if (accept) begin
          nxtMask = reqMask;
          nxtCnt  = '0;
          if (reqMask == 2'b00)  nxtPh = PH_SKIP;
          else if (reqWrite)     nxtPh = PH_WRITE;
          else                   nxtPh = PH_READ;
        end
      end
      PH_READ: begin
        if (cnt == RD_LAST) nxtPh = PH_DONE;
        else                nxtCnt = cnt + 1'b1;
      end
      PH_WRITE: begin
        if (cnt == WR_LAST) nxtPh = PH_DONE;
        else                nxtCnt = cnt + 1'b1;
      end
      PH_SKIP: nxtPh = PH_DONE;
      PH_DONE: nxtPh = PH_IDLE;
      default: nxtPh = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      maskQ <= '0;
      pinQ  <= pinsFor(PH_IDLE, '0, 2'b00);
    end else begin
      ph    <= nxtPh;
      cnt   <= nxtCnt;
      maskQ <= nxtMask;
      pinQ  <= pinsFor(nxtPh, nxtCnt, nxtMask);
    end
  end

  assign pins       = pinQ;
  assign dp.load    = accept;
  assign dp.capture = (ph == PH_SKIP) || ((ph == PH_READ) && (cnt == RD_LAST));

  // run length of write enable low, used by the timing checks below
  logic [CNT_W:0] weLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          weLowRun <= '0;
    else if (!pinQ.weN) weLowRun <= weLowRun + 1'b1;
    else                weLowRun <= '0;
  end

  // R4
  wr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinQ.weN |-> (!pinQ.ceN && !(pinQ.ubN && pinQ.lbN)));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinQ.weN) |-> (weLowRun >= (CNT_W+1)'(WP_N)));

  // R5
  drive_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinQ.driveEn) |-> (!pinQ.weN && weLowRun >= (CNT_W+1)'(HZ_N)));

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinQ.oeN |-> pinQ.weN);

  // R10
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.driveEn |-> pinQ.oeN);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.done |=> !pinQ.done);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.ready |-> (pinQ.ceN && !pinQ.done));

  // R7
  accept_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !pinQ.ready);

endmodule

// File: rtl/asram_path.sv
module asram_path
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           dp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (dp.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  // R3: one capture register per byte lane, masked lanes read as zero
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdQ[g*LANE_W +: LANE_W] <= '0;
      else if (dp.capture)
        rdQ[g*LANE_W +: LANE_W] <= maskQ[g] ? memDin[g*LANE_W +: LANE_W] : '0;
    end

    // R3
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dp.capture && !maskQ[g]) |=> (rdQ[g*LANE_W +: LANE_W] == '0));
  end

  assign memAddr = addrQ;
  assign memDout = dataQ;
  assign rdData  = rdQ;

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dp.load && dp.capture));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int T_CYCLE_NS = 45,
  parameter int T_ACC_NS   = 45,
  parameter int T_OE_NS    = 22,
  parameter int T_WP_NS    = 35,
  parameter int T_DS_NS    = 25,
  parameter int T_HZ_NS    = 18,
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDriveEn,
  input  logic [DATA_W-1:0] memDin
);

  pins_t   pins;
  dpStrb_t dp;

  asram_seq #(
    .CLK_NS    (CLK_NS),
    .T_CYCLE_NS(T_CYCLE_NS),
    .T_ACC_NS  (T_ACC_NS),
    .T_OE_NS   (T_OE_NS),
    .T_WP_NS   (T_WP_NS),
    .T_DS_NS   (T_DS_NS),
    .T_HZ_NS   (T_HZ_NS)
  ) uSeq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .pins    (pins),
    .dp      (dp)
  );

  asram_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .dp      (dp),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memDout (memDout),
    .rdData  (rdData)
  );

  assign reqReady   = pins.ready;
  assign doneValid  = pins.done;
  assign memCeN     = pins.ceN;
  assign memWeN     = pins.weN;
  assign memOeN     = pins.oeN;
  assign memUbN     = pins.ubN;
  assign memLbN     = pins.lbN;
  assign memDriveEn = pins.driveEn;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDriveEn && $past(memDriveEn)) |-> $stable(memDout));

endmodule

// File: tb/sim_asram_ctl.sv
`timescale 1ns/1ps
module sim_asram_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        doneValid;
  logic [15:0] rdData;
  logic        memCeN, memWeN, memOeN, memUbN, memLbN, memDriveEn;
  logic [16:0] memAddr;
  logic [15:0] memDout;
  logic [15:0] memDin = 16'hBEEF;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  asram_ctl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .doneValid(doneValid), .rdData(rdData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN), .memAddr(memAddr),
    .memDout(memDout), .memDriveEn(memDriveEn), .memDin(memDin)
  );

  // ---------------- memory model ----------------
  logic [15:0] memArr [int];
  int          rdAge = 0;
  logic        readActive;
  assign readActive = !memCeN && !memOeN && memWeN;

  function automatic logic [15:0] peek(input logic [16:0] a);
    return memArr.exists(int'(a)) ? memArr[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) rdAge <= readActive ? rdAge + 1 : 0;

  // data is valid only once the full access window has elapsed (11 cycles in)
  always @(negedge clk) begin
    logic [15:0] w;
    w = peek(memAddr);
    if (readActive && rdAge >= 11)
      memDin <= {(!memUbN ? w[15:8] : 8'h5A), (!memLbN ? w[7:0] : 8'h5A)};
    else
      memDin <= 16'hBEEF;
  end

  // the write lands on the rising edge of write enable
  always @(posedge memWeN) begin
    if (rstN && !memCeN) begin
      logic [15:0] w;
      w = peek(memAddr);
      if (!memLbN) w[7:0]  = memDriveEn ? memDout[7:0]  : 8'hEE;
      if (!memUbN) w[15:8] = memDriveEn ? memDout[15:8] : 8'hEE;
      memArr[int'(memAddr)] = w;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  int doneAt, ceLow, weLow, weRiseAt, oeLow, driveFirst, driveCnt, ubLow, lbLow;
  int addrBad, busyReady;
  logic [15:0] gotRd;

  task automatic runReq(input logic w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit holdBusy);
    int k;
    @(negedge clk);
    reqWrite = w; reqAddr = a; reqWdata = d; reqMask = m; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (holdBusy) begin
      reqWrite = 1'b1; reqAddr = a ^ 17'h00F0F; reqWdata = 16'hDEAD; reqMask = 2'b11;
    end else begin
      reqValid = 1'b0;
    end
    ceLow = 0; weLow = 0; weRiseAt = -1; oeLow = 0; driveFirst = -1; driveCnt = 0;
    ubLow = 0; lbLow = 0; addrBad = 0; busyReady = 0;
    k = 0;
    while (!doneValid && k < 100) begin
      if (!memCeN) begin
        ceLow++;
        if (memAddr != a) addrBad++;
      end
      if (!memWeN) begin weLow++; weRiseAt = k + 1; end
      if (!memOeN) oeLow++;
      if (memDriveEn) begin if (driveFirst < 0) driveFirst = k; driveCnt++; end
      if (!memUbN) ubLow++;
      if (!memLbN) lbLow++;
      if (reqReady) busyReady++;
      @(negedge clk);
      k++;
    end
    doneAt = k;
    gotRd = rdData;
    reqValid = 1'b0;
    @(negedge clk);
    chk("R7", "done width", int'(doneValid), 0);
    chk("R7", "ready after done", int'(reqReady), 1);
  endtask

  task automatic checkWrite(input string tag, input int expUb, input int expLb);
    chk("R4", {tag, " ce low cycles"}, ceLow, 13);
    chk("R4", {tag, " we low cycles"}, weLow, 12);
    chk("R4", {tag, " we rise cycle"}, weRiseAt, 12);
    chk("R5", {tag, " first drive cycle"}, driveFirst, 5);
    chk("R5", {tag, " drive cycles"}, driveCnt, 8);
    chk("R5", {tag, " oe low in write"}, oeLow, 0);
    chk("R3", {tag, " upper lane cycles"}, ubLow, expUb);
    chk("R3", {tag, " lower lane cycles"}, lbLow, expLb);
    chk("R7", {tag, " write done cycle"}, doneAt, 13);
    chk("R2", {tag, " address held"}, addrBad, 0);
  endtask

  task automatic doRead(input string tag, input logic [16:0] a, input logic [1:0] m,
                        input logic [15:0] exp);
    runReq(1'b0, a, 16'h0, m, 1'b0);
    chk("R2", {tag, " ce low cycles"}, ceLow, 12);
    chk("R2", {tag, " oe low cycles"}, oeLow, 12);
    chk("R10", {tag, " we low in read"}, weLow, 0);
    chk("R10", {tag, " drive in read"}, driveCnt, 0);
    chk("R2", {tag, " address held"}, addrBad, 0);
    chk("R7", {tag, " read done cycle"}, doneAt, 12);
    chk("R3", {tag, " read data"}, int'(gotRd), int'(exp));
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chk("R1", "ceN", int'(memCeN), 1);
    chk("R1", "weN", int'(memWeN), 1);
    chk("R1", "oeN", int'(memOeN), 1);
    chk("R1", "byte enables", int'({memUbN, memLbN}), 3);
    chk("R1", "drive", int'(memDriveEn), 0);
    chk("R1", "ready", int'(reqReady), 1);
    chk("R1", "done", int'(doneValid), 0);
  endtask

  task automatic testFullWord();
    runReq(1'b1, 17'h00010, 16'h1234, 2'b11, 1'b0);
    checkWrite("full", 13, 13);
    doRead("full", 17'h00010, 2'b11, 16'h1234);
  endtask

  task automatic testLanes();
    runReq(1'b1, 17'h00010, 16'hABCD, 2'b01, 1'b0);
    checkWrite("low lane R6", 0, 13);
    doRead("after low write R6", 17'h00010, 2'b11, 16'h12CD);
    runReq(1'b1, 17'h00010, 16'h5577, 2'b10, 1'b0);
    checkWrite("high lane R6", 13, 0);
    doRead("after high write R6", 17'h00010, 2'b11, 16'h55CD);
    doRead("lower only", 17'h00010, 2'b01, 16'h00CD);
    doRead("upper only", 17'h00010, 2'b10, 16'h5500);
  endtask

  task automatic testZeroMask();
    runReq(1'b1, 17'h00010, 16'hFFFF, 2'b00, 1'b0);
    chk("R8", "zero-mask write done cycle", doneAt, 1);
    chk("R8", "zero-mask write ce", ceLow, 0);
    chk("R8", "zero-mask write we", weLow, 0);
    doRead("zero-mask write left word R8", 17'h00010, 2'b11, 16'h55CD);
    runReq(1'b0, 17'h00010, 16'h0, 2'b00, 1'b0);
    chk("R8", "zero-mask read done cycle", doneAt, 1);
    chk("R8", "zero-mask read oe", oeLow, 0);
    chk("R8", "zero-mask read data", int'(gotRd), 0);
  endtask

  task automatic testTopAddress();
    runReq(1'b1, 17'h1FFFF, 16'hC3A5, 2'b11, 1'b0);
    checkWrite("top address", 13, 13);
    doRead("top address", 17'h1FFFF, 2'b11, 16'hC3A5);
    doRead("low word kept", 17'h00010, 2'b11, 16'h55CD);
  endtask

  task automatic testBusyIgnored();
    runReq(1'b0, 17'h1FFFF, 16'h0, 2'b11, 1'b1);
    chk("R7", "ready while busy", busyReady, 0);
    chk("R7", "address held under busy request", addrBad, 0);
    chk("R7", "busy read data", int'(gotRd), 16'hC3A5);
    doRead("busy target untouched R7", 17'h1FFFF ^ 17'h00F0F, 2'b11, 16'h0000);
  endtask

  // ---------------- sequencing ----------------
  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullWord();
    testLanes();
    testZeroMask();
    testTopAddress();
    testBusyIgnored();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule